// File: doc/BRIEF.md
# Smooth-Number Zero-Word Search Engine

This block walks through every product `seed · p0^e0 · p1^e1 · … · p(n-1)^e(n-1)` of a seed value and up to five small primes. It reports each product that lies strictly between `2^(W·LO)` and `2^(W·HI)` and that has at least one zero W-bit word below its most significant non-zero word. Such values make the multiplication step of a modular reduction cheaper, because a zero word in the multiplier removes a whole row of partial products. A host loads a seed and a prime list, pulses `start`, collects the hit stream and waits for `done`.

The enumeration works like an odometer. One working register is kept per prime, and all of them start at the seed. The register of the highest-numbered prime in use holds the current candidate. After each test, that candidate is multiplied by its own prime. When a product leaves the range, the engine steps down one register and multiplies that register by its prime. It keeps stepping down while the product is still out of range. The first in-range value it reaches is then copied into every higher register. The search ends when an out-of-range product occurs in register 0. Every multiplication by a prime is done one word per cycle with a carry register. The working width is HI words plus one guard word.

Top module: `sns_search`

## Requirements
- R1: While reset is held and after its release, until the first `start`: `done`, `hit_valid` and `hit_count` are all 0.
- R2: The values on the hit stream arrive in odometer order, as follows. The candidate is tested, then multiplied by its prime. When a product reaches `2^(W·HI)` or more, the engine steps down to lower registers, multiplying each by its prime, until one stays below the bound. That value is copied into all higher registers.
- R3: A value is reported only if it is strictly greater than `2^(W·LO)` and strictly less than `2^(W·HI)`. A candidate exactly equal to `2^(W·LO)` is not reported.
- R4: A value in range is reported only if some W-bit word below its most significant non-zero word is zero. Zero words above the most significant non-zero word do not count.
- R5: Each hit carries `hit_slot` equal to the number of hits before it in the current search. `hit_count` rises by exactly one per hit and equals the total number of hits at the end.
- R6: `done` rises when an out-of-range product occurs in register 0. It stays high with no further hits until the next `start`.
- R7: `prime_count` (1 to MAXP) selects how many primes are used. Prime j is taken from `primes[j·PW +: PW]`. Primes at positions `prime_count` and above have no effect on the hit stream.
- R8: A seed of `2^(W·HI)` or more yields no hits, and the search still reaches `done`.
- R9: A `start` pulse while idle or done reloads every register from `seed`, and in the next cycle `hit_count` is 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new search (taken only while idle or done) |
| seed | input | SEED_W | Starting value, non-zero, SEED_W ≤ (HI+1)·W |
| primes | input | MAXP·PW | Prime list, prime j in bits [j·PW +: PW], each ≥ 2 |
| prime_count | input | $clog2(MAXP+1) | Number of primes used, 1 to MAXP |
| hit_valid | output | 1 | One-cycle pulse: hit_value and hit_slot are valid |
| hit_value | output | W·HI | Reported product |
| hit_slot | output | SLOT_W | Output position of this hit |
| hit_count | output | SLOT_W | Hits found so far in this search |
| done | output | 1 | Search finished |

## Verification
The bench uses a reduced configuration of 8-bit words with a range of 2^16 to 2^32. For each search, it compares the full ordered hit list against an odometer walk computed arithmetically. The prime sets of three and five primes exercise the step-down and copy paths at every depth. A seed of exactly 2^16 separates the strict lower bound from the first in-range multiple. A seed whose top byte is zero but whose lower bytes are all non-zero shows that zero words above the leading word are ignored. An oversized seed and a prime list with junk in the unused slots show that out-of-range inputs and unselected primes leave the hit stream empty or unchanged.

// File: rtl/sns_pkg.sv
// Shared types for the smooth-number search engine.
package sns_pkg;
    // Controller states: load, test candidate, serial multiply, evaluate product, finished.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_MUL,
        ST_EVAL,
        ST_FIN
    } sns_state_t;
endpackage

// File: rtl/sns_scan.sv
// Range test and zero-word detector for one wide candidate.
// Assumes HI >= 2 and LO < HI. The input holds HI words plus one guard word.
// hit is high when LO_BOUND < x < 2^(W*HI) and some word below the
// most significant non-zero word equals zero.
module sns_scan #(
    parameter int W  = 32,
    parameter int LO = 11,
    parameter int HI = 16
) (
    input  logic [(HI+1)*W-1:0] x,
    output logic                hit
);
    localparam int TOT_W = (HI + 1) * W;
    localparam logic [TOT_W-1:0] LOW_BOUND = {{(TOT_W-1){1'b0}}, 1'b1} << (W * LO);

    logic           in_range;
    logic [HI-2:0]  gap;

    // Range: guard word clear and strictly above the lower bound.
    always_comb in_range = (x[TOT_W-1 -: W] == '0) && (x > LOW_BOUND);

    // One flag per word that is zero while something above it is non-zero.
    for (genvar i = 0; i < HI - 1; i++) begin : g_gap
        assign gap[i] = (x[i*W +: W] == '0) && (|x[HI*W-1:(i+1)*W]);
    end

    // Final hit decision.
    always_comb hit = in_range && (|gap);
endmodule

// File: rtl/sns_word_mul.sv
// Word-serial multiply of a wide operand by a small factor.
// One word per cycle while run is high, starting at word 0. The carry out of
// each word feeds the next. idx and carry clear whenever run is low.
// carry still holds the final carry in the cycle after the last word.
module sns_word_mul #(
    parameter int W  = 32,
    parameter int PW = 8,
    parameter int NW = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [W-1:0]            word_in,
    input  logic [PW-1:0]           prime,
    output logic [W-1:0]            word_out,
    output logic [$clog2(NW)-1:0]   idx,
    output logic                    last,
    output logic [PW-1:0]           carry
);
    localparam int IDX_W = $clog2(NW);

    logic [W+PW-1:0] acc;

    // Partial product of the current word plus the incoming carry.
    always_comb begin
        acc      = ({{PW{1'b0}}, word_in} * {{W{1'b0}}, prime}) + {{W{1'b0}}, carry};
        word_out = acc[W-1:0];
        last     = (idx == IDX_W'(NW - 1));
    end

    // Word index and carry register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idx   <= '0;
            carry <= '0;
        end else begin
            carry <= acc[W +: PW];
            idx   <= last ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/sns_search.sv
// Smooth-number zero-word search engine (top).
// Keeps one wide register per prime. The register at index prime_count-1 is the
// candidate. Each candidate is tested, then multiplied by its prime. An
// out-of-range product steps down to lower registers, and the first in-range
// value is copied upward. Assumes seed != 0, every used prime >= 2,
// 1 <= prime_count <= MAXP, MAXP >= 2 and SEED_W <= (HI+1)*W.
module sns_search
    import sns_pkg::*;
#(
    parameter int W      = 32,
    parameter int LO     = 11,
    parameter int HI     = 16,
    parameter int PW     = 8,
    parameter int MAXP   = 5,
    parameter int SEED_W = 64,
    parameter int SLOT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [SEED_W-1:0]           seed,
    input  logic [MAXP*PW-1:0]          primes,
    input  logic [$clog2(MAXP+1)-1:0]   prime_count,
    output logic                        hit_valid,
    output logic [W*HI-1:0]             hit_value,
    output logic [SLOT_W-1:0]           hit_slot,
    output logic [SLOT_W-1:0]           hit_count,
    output logic                        done
);
    localparam int NW    = HI + 1;
    localparam int TOT_W = NW * W;
    localparam int IDX_W = $clog2(NW);
    localparam int SEL_W = $clog2(MAXP);

    sns_state_t          state;
    logic [TOT_W-1:0]    c_q [MAXP];
    logic [PW-1:0]       p_q [MAXP];
    logic [SEL_W-1:0]    sel;
    logic [SEL_W-1:0]    top;
    logic [TOT_W-1:0]    cand;
    logic                cand_hit;
    logic [W-1:0]        mul_in;
    logic [W-1:0]        mul_out;
    logic [IDX_W-1:0]    mul_idx;
    logic                mul_last;
    logic [PW-1:0]       mul_carry;
    logic                overflow;

    // Operand selection for the scanner and the serial multiplier.
    always_comb begin
        cand     = c_q[top];
        mul_in   = c_q[sel][int'(mul_idx)*W +: W];
        overflow = (c_q[sel][TOT_W-1 -: W] != '0) || (mul_carry != '0);
        done     = (state == ST_FIN);
    end

    sns_scan #(.W(W), .LO(LO), .HI(HI)) u_scan (
        .x   (cand),
        .hit (cand_hit)
    );

    sns_word_mul #(.W(W), .PW(PW), .NW(NW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_MUL),
        .word_in  (mul_in),
        .prime    (p_q[sel]),
        .word_out (mul_out),
        .idx      (mul_idx),
        .last     (mul_last),
        .carry    (mul_carry)
    );

    // Controller and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel       <= '0;
            top       <= '0;
            hit_valid <= 1'b0;
            hit_value <= '0;
            hit_slot  <= '0;
            hit_count <= '0;
            for (int j = 0; j < MAXP; j++) begin
                c_q[j] <= '0;
                p_q[j] <= '0;
            end
        end else begin
            hit_valid <= 1'b0;
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        for (int j = 0; j < MAXP; j++) begin
                            c_q[j] <= TOT_W'(seed);
                            p_q[j] <= primes[j*PW +: PW];
                        end
                        top       <= SEL_W'(prime_count - 1'b1);
                        hit_count <= '0;
                        state     <= ST_TEST;
                    end
                end
                ST_TEST: begin
                    if (cand_hit) begin
                        hit_valid <= 1'b1;
                        hit_value <= cand[W*HI-1:0];
                        hit_slot  <= hit_count;
                        hit_count <= hit_count + 1'b1;
                    end
                    sel   <= top;
                    state <= ST_MUL;
                end
                ST_MUL: begin
                    c_q[sel][int'(mul_idx)*W +: W] <= mul_out;
                    if (mul_last) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (overflow) begin
                        if (sel == '0) begin
                            state <= ST_FIN;
                        end else begin
                            sel   <= sel - 1'b1;
                            state <= ST_MUL;
                        end
                    end else begin
                        for (int j = 0; j < MAXP; j++) begin
                            if (j > int'(sel)) c_q[j] <= c_q[sel];
                        end
                        state <= ST_TEST;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sns_search_chk.sv
// Property checker for sns_search, attached by bind. Observes only top ports.
module sns_search_chk #(
    parameter int W      = 32,
    parameter int LO     = 11,
    parameter int HI     = 16,
    parameter int SLOT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              hit_valid,
    input logic [W*HI-1:0]   hit_value,
    input logic [SLOT_W-1:0] hit_slot,
    input logic [SLOT_W-1:0] hit_count,
    input logic              done
);
    localparam logic [W*HI-1:0] LOW_BOUND = {{(W*HI-1){1'b0}}, 1'b1} << (W * LO);

    // R3: every reported value lies above the strict lower bound.
    assert_hit_above_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_value > LOW_BOUND));

    // R5: a hit's slot is the count before it was added.
    assert_slot_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_slot == hit_count - 1'b1));

    // R5: the count only steps by one, or restarts at zero.
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |->
            ((hit_count == $past(hit_count) + 1'b1) || (hit_count == '0)));

    // R6: no hit is presented while finished.
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !hit_valid);

    // R6: finished stays set until a new start.
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a start from the finished state clears the count and done.
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> ((hit_count == '0) && !done));
endmodule

bind sns_search sns_search_chk #(.W(W), .LO(LO), .HI(HI), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit_valid (hit_valid),
    .hit_value (hit_value),
    .hit_slot  (hit_slot),
    .hit_count (hit_count),
    .done      (done)
);

// File: tb/sns_search_test.sv
// Bench for sns_search in a reduced configuration: 8-bit words, range 2^16..2^32.
module sns_search_test;
    localparam int CLK_PERIOD = 10;
    localparam int W      = 8;
    localparam int LO     = 2;
    localparam int HI     = 4;
    localparam int PW     = 8;
    localparam int MAXP   = 5;
    localparam int SEED_W = 40;
    localparam int SLOT_W = 16;
    localparam int CNT_W  = $clog2(MAXP + 1);
    localparam longint LO_LIM = 64'd1 << (W * LO);
    localparam longint HI_LIM = 64'd1 << (W * HI);
    localparam longint WMASK  = (64'd1 << W) - 1;

    logic                 clk;
    logic                 rst_n;
    logic                 start;
    logic [SEED_W-1:0]    seed;
    logic [MAXP*PW-1:0]   primes;
    logic [CNT_W-1:0]     prime_count;
    logic                 hit_valid;
    logic [W*HI-1:0]      hit_value;
    logic [SLOT_W-1:0]    hit_slot;
    logic [SLOT_W-1:0]    hit_count;
    logic                 done;

    int     checks;
    int     fails;
    int     cyc;
    longint exp_q[$];
    longint got_v[$];
    int     got_s[$];

    sns_search #(.W(W), .LO(LO), .HI(HI), .PW(PW), .MAXP(MAXP),
                 .SEED_W(SEED_W), .SLOT_W(SLOT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .primes(primes),
        .prime_count(prime_count), .hit_valid(hit_valid), .hit_value(hit_value),
        .hit_slot(hit_slot), .hit_count(hit_count), .done(done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Hit stream capture, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && hit_valid) begin
            got_v.push_back(longint'(hit_value));
            got_s.push_back(int'(hit_slot));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R6 watchdog: actual %0d cycles expected below 190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reportable value per R3 and R4.
    function automatic bit is_hit(input longint x);
        int t;
        if (x <= LO_LIM || x >= HI_LIM) return 1'b0;
        t = 0;
        for (int i = 0; i < HI; i++)
            if (((x >> (W * i)) & WMASK) != 0) t = i;
        for (int i = 0; i < t; i++)
            if (((x >> (W * i)) & WMASK) == 0) return 1'b1;
        return 1'b0;
    endfunction

    // Arithmetic odometer walk producing the expected ordered hit list (R2).
    task automatic model(input longint s, input int np, input int pr[MAXP]);
        longint c[MAXP];
        int     k;
        bit     running;
        exp_q.delete();
        for (int j = 0; j < MAXP; j++) c[j] = s;
        running = 1'b1;
        while (running) begin
            if (is_hit(c[np-1])) exp_q.push_back(c[np-1]);
            c[np-1] = c[np-1] * longint'(pr[np-1]);
            if (c[np-1] >= HI_LIM) begin
                k = np - 1;
                do begin
                    if (k == 0) begin
                        running = 1'b0;
                        break;
                    end
                    k--;
                    c[k] = c[k] * longint'(pr[k]);
                end while (c[k] >= HI_LIM);
                if (running)
                    for (int j = k + 1; j < np; j++) c[j] = c[k];
            end
        end
    endtask

    // One search: drive, wait for done, compare the full list.
    task automatic run(input longint s, input int np, input int pr[MAXP]);
        int n;
        int sz;
        model(s, np, pr);
        got_v.delete();
        got_s.delete();
        @(negedge clk);
        seed        = SEED_W'(s);
        prime_count = CNT_W'(np);
        for (int j = 0; j < MAXP; j++) primes[j*PW +: PW] = PW'(pr[j]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(hit_count == 0 && !done, "R9", "count/done after start", longint'(hit_count), 0);
        n = 0;
        while (!done && n < 60000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(done, "R6", "done at end", longint'(done), 1);
        check(got_v.size() == exp_q.size(), "R2", "hit list length",
              longint'(got_v.size()), longint'(exp_q.size()));
        for (int i = 0; i < got_v.size() && i < exp_q.size(); i++) begin
            check(got_v[i] == exp_q[i], "R2", "hit value in order", got_v[i], exp_q[i]);
            check(got_s[i] == i, "R5", "hit slot", longint'(got_s[i]), longint'(i));
        end
        check(int'(hit_count) == exp_q.size(), "R5", "final hit_count",
              longint'(hit_count), longint'(exp_q.size()));
        sz = got_v.size();
        repeat (6) @(negedge clk);
        check(got_v.size() == sz && done, "R6", "quiet after done",
              longint'(got_v.size()), longint'(sz));
    endtask

    initial begin
        checks = 0;
        fails  = 0;
        cyc    = 0;
        rst_n  = 1'b0;
        start  = 1'b0;
        seed   = '0;
        primes = '0;
        prime_count = '0;
        repeat (3) @(negedge clk);
        check(!done && !hit_valid && hit_count == 0, "R1", "state in reset",
              longint'(hit_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !hit_valid && hit_count == 0, "R1", "idle after reset",
              longint'({done, hit_valid}), 0);

        // R2 three-prime walk from seed 1.
        run(1, 3, '{3, 5, 7, 0, 0});
        // R2 five-prime walk, deepest step-down and copy paths.
        run(1, 5, '{3, 5, 7, 11, 13});
        // R3 boundary: seed exactly 2^16 is excluded, 3*2^16 is the first hit.
        run(64'd65536, 1, '{3, 0, 0, 0, 0});
        check(got_v.size() > 0 && got_v[0] == 64'd196608, "R3", "first hit above bound",
              got_v.size() > 0 ? got_v[0] : -1, 196608);
        // R4: 0x00010203 has a zero only above its leading word, so it is not reported.
        run(64'h10203, 1, '{3, 0, 0, 0, 0});
        check(got_v.size() == 0 || got_v[0] != 64'h10203, "R4", "leading zero ignored",
              got_v.size() > 0 ? got_v[0] : 0, 0);
        // R7: junk in unused prime slots has no effect.
        run(7, 2, '{5, 3, 200, 251, 1});
        // R8: seed above range gives no hits.
        run(64'd1 << 33, 2, '{3, 5, 0, 0, 0});
        check(got_v.size() == 0, "R8", "no hits for large seed", longint'(got_v.size()), 0);
        // R9: restart after done, different seed and primes.
        run(17, 4, '{13, 11, 7, 3, 0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule